// File: doc/BRIEF.md
# Pulse-Sequenced Control Program

This block is a small library of control modules. Each module turns one structured statement into hardware: do nothing, emit, wait one cycle, sequence, two-way branch, fork-join and conditional loop. Every module takes a one-cycle start pulse. It returns a one-cycle finish pulse when the statement completes and raises a shout pulse when one of its emit leaves fires. Composite modules start their children and listen to them purely through these pulses. A program is therefore built by instantiating modules inside one another, with no central controller.

The top module wires one fixed example program out of the library:

`seq( emit, seq( par( seq(wait, emit), if(cond_sel, wait, seq(skip, seq(wait, wait))) ), while(loop_cond, seq(wait, emit)) ) )`

A pulse on `go` runs the program once. The `shout` output carries the OR of all emit leaves, and `done` pulses once when the whole program has terminated.

Named states and transitions:
- The fork-join synchroniser has three states. `JN_IDLE` moves to `JN_LEFT_DONE` when only the left child finishes, and to `JN_RIGHT_DONE` when only the right child finishes. It stays in `JN_IDLE` (and issues finish) when both children finish in the same cycle. `JN_LEFT_DONE` returns to `JN_IDLE` on the right child's finish, and `JN_RIGHT_DONE` returns to `JN_IDLE` on the left child's finish. Each of these returns issues finish.
- The wait module has no named states. It is a reset-low register chain of `LATENCY` stages.

Top module: `ctl_program`

## Requirements
- R1: An emit leaf drives shout in the same cycle as its start and finishes in that cycle. In the top module, `shout` is high in the cycle `go` is high.
- R2: A skip leaf finishes in the same cycle as its start and never shouts. In the top module, the else branch therefore lasts exactly two cycles.
- R3: A wait leaf finishes exactly one cycle after its start, through a register that is low after reset. In the top module, `shout` is high in the cycle after `go`.
- R4: In a sequence, the first child is started by the sequence's start, the second child is started by the first child's finish, and the sequence finishes with the second child. In the top module, `done` is never high in the cycle of `go`.
- R5: A composite's shout is the OR of its children's shouts.
- R6: A branch routes start to the then-child when its condition is high in the start cycle and to the else-child otherwise. Its finish is the OR of both children's finishes.
- R7: A fork-join starts both children together. It issues a single finish in the cycle the later child finishes, including the cycle in which both finish together, and then returns to idle.
- R8: A loop tests its condition in the cycle it starts and in every cycle its body finishes. A true test starts the body; a false test finishes the loop in that same cycle. Each pass of the example body shouts one cycle after it starts.
- R9: After reset, and whenever no program is running, `shout` and `done` stay low regardless of `cond_sel` and `loop_cond`.
- R10: Each `go` pulse, issued only while no program is running, yields exactly one `done` pulse. With `cond_sel` high that pulse comes N+1 cycles after `go`, and with `cond_sel` low N+2 cycles after, where N is the number of loop passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | One-cycle start pulse for the program |
| cond_sel | input | 1 | Branch condition, sampled in the `go` cycle |
| loop_cond | input | 1 | Loop condition, sampled in every loop test cycle |
| shout | output | 1 | OR of all emit leaves |
| done | output | 1 | One-cycle program finish pulse |

## Verification
The two children of the fork-join can finish in the same cycle. When `cond_sel` is high, the one-cycle then-branch completes alongside the wait-then-emit branch. The synchroniser must then take its `JN_IDLE` path straight to finish, without going through a half-done state. The bench provokes this with `cond_sel` high and judges it by `done` arriving exactly one cycle after `go` when the loop makes no passes. It also checks that no second `done` follows. The same runs with `cond_sel` low exercise the ordered case, and a loop test falling on the join cycle checks the zero-cycle loop exit.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    typedef enum logic [1:0] {
        JN_IDLE       = 2'd0,
        JN_LEFT_DONE  = 2'd1,
        JN_RIGHT_DONE = 2'd2
    } join_state_e;

endpackage

// File: rtl/ctl_leaf.sv
// Leaf statements: skip, emit and a reset-low wait of LATENCY cycles.
module ctl_skip (
    input  logic start,
    output logic shout,
    output logic fin
);
    assign shout = 1'b0;
    assign fin   = start;
endmodule

module ctl_emit (
    input  logic start,
    output logic shout,
    output logic fin
);
    assign shout = start;
    assign fin   = start;
endmodule

module ctl_wait #(
    parameter int LATENCY = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic shout,
    output logic fin
);
    logic [LATENCY-1:0] pipe_q;

    generate
        if (LATENCY == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= start;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= {pipe_q[LATENCY-2:0], start};
            end
        end
    endgenerate

    assign shout = 1'b0;
    assign fin   = pipe_q[LATENCY-1];
endmodule

// File: rtl/ctl_compose.sv
// Composite statements that only route pulses: sequence, branch, loop.
module ctl_seq (
    input  logic start,
    output logic a_start,
    input  logic a_shout,
    input  logic a_fin,
    output logic b_start,
    input  logic b_shout,
    input  logic b_fin,
    output logic shout,
    output logic fin
);
    assign a_start = start;
    assign b_start = a_fin;
    assign shout   = a_shout | b_shout;
    assign fin     = b_fin;
endmodule

module ctl_ifelse (
    input  logic start,
    input  logic cond,
    output logic t_start,
    input  logic t_shout,
    input  logic t_fin,
    output logic e_start,
    input  logic e_shout,
    input  logic e_fin,
    output logic shout,
    output logic fin
);
    assign t_start = start & cond;
    assign e_start = start & ~cond;
    assign shout   = t_shout | e_shout;
    assign fin     = t_fin | e_fin;
endmodule

module ctl_while (
    input  logic start,
    input  logic cond,
    output logic body_start,
    input  logic body_shout,
    input  logic body_fin,
    output logic shout,
    output logic fin
);
    logic test;
    assign test       = start | body_fin;
    assign body_start = test & cond;
    assign fin        = test & ~cond;
    assign shout      = body_shout;
endmodule

// File: rtl/ctl_par.sv
// Fork-join: starts both children, synchroniser merges the finishes.
module ctl_join
    import ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_fin,
    input  logic r_fin,
    output logic fin
);
    join_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= JN_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            JN_IDLE: begin
                if (l_fin && !r_fin)      state_d = JN_LEFT_DONE;
                else if (r_fin && !l_fin) state_d = JN_RIGHT_DONE;
            end
            JN_LEFT_DONE:  if (r_fin) state_d = JN_IDLE;
            JN_RIGHT_DONE: if (l_fin) state_d = JN_IDLE;
            default:       state_d = JN_IDLE;
        endcase
    end

    always_comb begin
        fin = 1'b0;
        unique case (state_q)
            JN_IDLE:       fin = l_fin & r_fin;
            JN_LEFT_DONE:  fin = r_fin;
            JN_RIGHT_DONE: fin = l_fin;
            default:       fin = 1'b0;
        endcase
    end
endmodule

module ctl_par (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic l_start,
    input  logic l_shout,
    input  logic l_fin,
    output logic r_start,
    input  logic r_shout,
    input  logic r_fin,
    output logic shout,
    output logic fin
);
    assign l_start = start;
    assign r_start = start;
    assign shout   = l_shout | r_shout;

    ctl_join u_join (
        .clk   (clk),
        .rst_n (rst_n),
        .l_fin (l_fin),
        .r_fin (r_fin),
        .fin   (fin)
    );
endmodule

// File: rtl/ctl_program.sv
// Example program built by instantiation:
// seq(emit, seq(par(seq(wait,emit), if(c, wait, seq(skip, seq(wait,wait)))),
//               while(l, seq(wait,emit))))
module ctl_program #(
    parameter int WAIT_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic cond_sel,
    input  logic loop_cond,
    output logic shout,
    output logic done
);
    // top-level sequence: emit then rest
    logic e0_st, e0_sh, e0_fn, rest_st, rest_sh, rest_fn;
    ctl_seq u_top (.start(go), .a_start(e0_st), .a_shout(e0_sh), .a_fin(e0_fn),
                   .b_start(rest_st), .b_shout(rest_sh), .b_fin(rest_fn),
                   .shout(shout), .fin(done));
    ctl_emit u_e0 (.start(e0_st), .shout(e0_sh), .fin(e0_fn));

    // rest: fork-join then loop
    logic pr_st, pr_sh, pr_fn, lp_st, lp_sh, lp_fn;
    ctl_seq u_rest (.start(rest_st), .a_start(pr_st), .a_shout(pr_sh), .a_fin(pr_fn),
                    .b_start(lp_st), .b_shout(lp_sh), .b_fin(lp_fn),
                    .shout(rest_sh), .fin(rest_fn));

    // fork-join
    logic l_st, l_sh, l_fn, r_st, r_sh, r_fn;
    ctl_par u_par (.clk(clk), .rst_n(rst_n), .start(pr_st),
                   .l_start(l_st), .l_shout(l_sh), .l_fin(l_fn),
                   .r_start(r_st), .r_shout(r_sh), .r_fin(r_fn),
                   .shout(pr_sh), .fin(pr_fn));

    // left branch: wait then emit
    logic w1_st, w1_sh, w1_fn, e1_st, e1_sh, e1_fn;
    ctl_seq u_left (.start(l_st), .a_start(w1_st), .a_shout(w1_sh), .a_fin(w1_fn),
                    .b_start(e1_st), .b_shout(e1_sh), .b_fin(e1_fn),
                    .shout(l_sh), .fin(l_fn));
    ctl_wait #(.LATENCY(WAIT_CYCLES)) u_w1 (.clk(clk), .rst_n(rst_n), .start(w1_st),
                                           .shout(w1_sh), .fin(w1_fn));
    ctl_emit u_e1 (.start(e1_st), .shout(e1_sh), .fin(e1_fn));

    // right branch: if(cond_sel, wait, seq(skip, seq(wait, wait)))
    logic t_st, t_sh, t_fn, el_st, el_sh, el_fn;
    ctl_ifelse u_if (.start(r_st), .cond(cond_sel),
                     .t_start(t_st), .t_shout(t_sh), .t_fin(t_fn),
                     .e_start(el_st), .e_shout(el_sh), .e_fin(el_fn),
                     .shout(r_sh), .fin(r_fn));
    ctl_wait #(.LATENCY(WAIT_CYCLES)) u_w2 (.clk(clk), .rst_n(rst_n), .start(t_st),
                                           .shout(t_sh), .fin(t_fn));

    logic sk_st, sk_sh, sk_fn, ww_st, ww_sh, ww_fn;
    ctl_seq u_else (.start(el_st), .a_start(sk_st), .a_shout(sk_sh), .a_fin(sk_fn),
                    .b_start(ww_st), .b_shout(ww_sh), .b_fin(ww_fn),
                    .shout(el_sh), .fin(el_fn));
    ctl_skip u_sk (.start(sk_st), .shout(sk_sh), .fin(sk_fn));

    logic w3_st, w3_sh, w3_fn, w4_st, w4_sh, w4_fn;
    ctl_seq u_ww (.start(ww_st), .a_start(w3_st), .a_shout(w3_sh), .a_fin(w3_fn),
                  .b_start(w4_st), .b_shout(w4_sh), .b_fin(w4_fn),
                  .shout(ww_sh), .fin(ww_fn));
    ctl_wait #(.LATENCY(WAIT_CYCLES)) u_w3 (.clk(clk), .rst_n(rst_n), .start(w3_st),
                                           .shout(w3_sh), .fin(w3_fn));
    ctl_wait #(.LATENCY(WAIT_CYCLES)) u_w4 (.clk(clk), .rst_n(rst_n), .start(w4_st),
                                           .shout(w4_sh), .fin(w4_fn));

    // loop: while(loop_cond, seq(wait, emit))
    logic bd_st, bd_sh, bd_fn;
    ctl_while u_loop (.start(lp_st), .cond(loop_cond),
                      .body_start(bd_st), .body_shout(bd_sh), .body_fin(bd_fn),
                      .shout(lp_sh), .fin(lp_fn));

    logic w5_st, w5_sh, w5_fn, e2_st, e2_sh, e2_fn;
    ctl_seq u_body (.start(bd_st), .a_start(w5_st), .a_shout(w5_sh), .a_fin(w5_fn),
                    .b_start(e2_st), .b_shout(e2_sh), .b_fin(e2_fn),
                    .shout(bd_sh), .fin(bd_fn));
    ctl_wait #(.LATENCY(WAIT_CYCLES)) u_w5 (.clk(clk), .rst_n(rst_n), .start(w5_st),
                                           .shout(w5_sh), .fin(w5_fn));
    ctl_emit u_e2 (.start(e2_st), .shout(e2_sh), .fin(e2_fn));
endmodule

// File: rtl/ctl_program_checker.sv
module ctl_program_checker (
    input logic clk,
    input logic rst_n,
    input logic go,
    input logic cond_sel,
    input logic loop_cond,
    input logic shout,
    input logic done
);
    // tracks whether a program run is in flight (set by go, cleared by done)
    logic run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= (run_q | go) & ~done;
    end

    // R1: emit at the head of the program shouts with go
    p_emit_same_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> shout);

    // R3: the wait-then-emit branch shouts one cycle after go
    p_wait_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> shout);

    // R4: the program never completes in its own start cycle
    p_no_zero_time_r4: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !done);

    // R9: quiet outside a run
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !go) |-> (!shout && !done));

    // R10: a finish pulse lasts one cycle
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: finish only while a run is in flight
    p_done_in_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> run_q);

    logic unused_ok;
    assign unused_ok = cond_sel ^ loop_cond;
endmodule

bind ctl_program ctl_program_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .cond_sel  (cond_sel),
    .loop_cond (loop_cond),
    .shout     (shout),
    .done      (done)
);

// File: tb/ctl_program_tb_top.sv
`timescale 1ns/1ps
module ctl_program_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic go = 1'b0;
    logic cond_sel = 1'b0;
    logic loop_cond = 1'b0;
    logic shout, done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ctl_program dut_i (
        .clk(clk), .rst_n(rst_n), .go(go), .cond_sel(cond_sel),
        .loop_cond(loop_cond), .shout(shout), .done(done)
    );

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // One program run: sel picks the branch, passes = loop iterations.
    // Cycle k=0 is the go cycle; join cycle J = 1 (sel high) or 2 (sel low).
    task automatic run_program(input logic sel, input int passes, input string req);
        int j;
        int done_cnt;
        j = sel ? 1 : 2;
        done_cnt = 0;
        for (int k = 0; k <= j + passes + 3; k++) begin
            @(negedge clk);
            go        = (k == 0);
            cond_sel  = (k == 0) ? sel : ~sel;
            loop_cond = (k >= j) && (k < j + passes);
            #4;
            // R1 at k=0, R3/R5 at k=1, R8 one cycle after each body start
            check(req, $sformatf("shout k=%0d sel=%0b n=%0d", k, sel, passes), shout,
                  (k == 0) || (k == 1) || (k > j && k <= j + passes));
            // R7/R10 finish timing, R2 via the two-cycle else branch
            check(req, $sformatf("done k=%0d sel=%0b n=%0d", k, sel, passes), done,
                  (k == j + passes));
            if (done) done_cnt++;
        end
        check("R10", "one done per go", done_cnt == 1, 1'b1);
        @(negedge clk);
        go = 1'b0; loop_cond = 1'b0;
    endtask

    task automatic test_reset();
        @(negedge clk);
        check("R9", "shout in reset", shout, 1'b0);
        check("R9", "done in reset", done, 1'b0);
    endtask

    task automatic test_idle_inputs();
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            go = 1'b0;
            cond_sel = k[0];
            loop_cond = ~k[1];
            #4;
            check("R9", "idle shout", shout, 1'b0);
            check("R9", "idle done", done, 1'b0);
        end
    endtask

    initial begin
        test_reset();
        @(negedge clk);
        rst_n = 1'b1;
        test_idle_inputs();
        run_program(1'b1, 0, "R7");   // simultaneous join, zero-pass loop (R8)
        run_program(1'b0, 0, "R2");   // skip then two waits, ordered join (R6)
        run_program(1'b1, 2, "R8");
        run_program(1'b0, 3, "R4");
        run_program(1'b1, 1, "R5");
        run_program(1'b0, 1, "R6");
        test_idle_inputs();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule